// File: doc/BRIEF.md
# Banked Shadow Register File

This block is a 32-entry integer register file with two combinational read ports and one write port. Eight of its indices (8, 9, 10, 11, 12, 13, 14 and 25) have a second, shadow copy. That copy is used while the core runs privileged firmware. The other indices have a single copy that both modes share. A mode bit selects which copy of a banked index the ports reach. Switching modes copies no data: the reads see the new bank from the cycle after the switch.

The mode changes on three requests. A trap entry moves the core into firmware mode. An exception return moves it back to normal mode, but only when bit 0 of the saved restart address is 0. A direct bank request names the bank it wants. Asking for the bank that is already selected is flagged as an error. The file comes out of reset in firmware mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset, `shadow_mode` is 1, `switch_err` is 0 and every index reads zero on both ports.
- R2: For indices 8 to 14 and 25, a write goes only to the copy of the bank selected in the cycle of the write. A read returns the copy of the bank selected now. The two copies of an index hold independent values.
- R3: Every other index, including the boundaries 7, 15, 24 and 26, has one copy that both modes share.
- R4: When `trap_enter` is high, `shadow_mode` is 1 in the next cycle. If the block was already in firmware mode, this raises no error.
- R5: When `trap_return` is high and `ret_addr_lsb` is 0, the block goes to normal mode (`shadow_mode` = 0) in the next cycle. When `ret_addr_lsb` is 1, the mode is unchanged and no error is raised.
- R6: A request for the bank that is already selected raises `switch_err` for exactly the next cycle and leaves the mode unchanged. This covers `trap_return` with `ret_addr_lsb` = 0 while in normal mode, and `sel_req` with `sel_shadow` equal to the current mode.
- R7: `sel_req` with `sel_shadow` set to the other mode selects that mode in the next cycle. `sel_shadow` = 1 means firmware mode.
- R8: Index 31 reads as zero in both modes, and writes to it are ignored.
- R9: A write becomes visible on the read ports in the cycle after it is accepted. Each read port returns the value of its own index, independent of the other port.
- R10: When several requests arrive in the same cycle, `trap_enter` wins over `trap_return`, and `trap_return` wins over `sel_req`. A request that loses is ignored and cannot raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_data | input | 64 | Write data |
| trap_enter | input | 1 | Trap entry strobe |
| trap_return | input | 1 | Exception return strobe |
| ret_addr_lsb | input | 1 | Bit 0 of the saved restart address |
| sel_req | input | 1 | Direct bank request strobe |
| sel_shadow | input | 1 | Bank asked for by `sel_req` (1 = firmware) |
| shadow_mode | output | 1 | Current mode (1 = firmware, shadow bank) |
| switch_err | output | 1 | One-cycle flag for a redundant bank request |

## Verification
The assertions check the mode machine on every cycle:
- a trap entry always lands in firmware mode;
- a return to normal mode while already in normal mode always raises the error flag;
- an error never comes with a mode change;
- the mode holds when no request is present;
- index 31 always reads zero.

Only the bench scenarios can show data steering. Those scenarios cover a banked index keeping two distinct values across mode switches, and an unbanked neighbour such as 7, 15, 24 or 26 sharing one value. They also cover the one-cycle write-to-read latency and the outcome of simultaneous requests.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trap_enter,
  input  logic              trap_return,
  input  logic              ret_addr_lsb,
  input  logic              sel_req,
  input  logic              sel_shadow,
  output logic              shadow_mode,
  output logic              switch_err
);
  localparam int NREG   = 1 << IDX_W;
  localparam int NSHAD  = 8;
  localparam int SLOT_W = $clog2(NSHAD);
  localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NREG - 1);

  logic [DATA_W-1:0] norm_q [NREG];
  logic [DATA_W-1:0] shad_q [NSHAD];
  logic mode_q, mode_d, err_q, err_d;

  function automatic logic banked(input logic [IDX_W-1:0] i);
    return (i >= IDX_W'(8) && i <= IDX_W'(14)) || i == IDX_W'(25);
  endfunction

  function automatic logic [SLOT_W-1:0] slot(input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] off;
    off = i - IDX_W'(8);
    return (i == IDX_W'(25)) ? SLOT_W'(NSHAD - 1) : off[SLOT_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] fetch(input logic [IDX_W-1:0] i, input logic m);
    if (i == ZERO_IDX)      return '0;
    if (m && banked(i))     return shad_q[slot(i)];
    return norm_q[i];
  endfunction

  assign rd_a_data   = fetch(rd_a_idx, mode_q);
  assign rd_b_data   = fetch(rd_b_idx, mode_q);
  assign shadow_mode = mode_q;
  assign switch_err  = err_q;

  always_comb begin
    mode_d = mode_q;
    err_d  = 1'b0;
    if (trap_enter) begin
      mode_d = 1'b1;
    end else if (trap_return && !ret_addr_lsb) begin
      if (!mode_q) err_d = 1'b1;
      else         mode_d = 1'b0;
    end else if (sel_req) begin
      if (sel_shadow == mode_q) err_d = 1'b1;
      else                      mode_d = sel_shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      err_q  <= 1'b0;
      for (int k = 0; k < NREG; k++)  norm_q[k] <= '0;
      for (int k = 0; k < NSHAD; k++) shad_q[k] <= '0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
      if (wr_en && wr_idx != ZERO_IDX) begin
        if (mode_q && banked(wr_idx)) shad_q[slot(wr_idx)] <= wr_data;
        else                          norm_q[wr_idx] <= wr_data;
      end
    end
  end

  assert_trap_to_fw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> shadow_mode);

  assert_redundant_ret_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_return && !ret_addr_lsb && !shadow_mode && !trap_enter) |=> switch_err);

  assert_err_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    switch_err |-> $stable(shadow_mode));

  assert_idle_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_enter && !trap_return && !sel_req) |=> ($stable(shadow_mode) && !switch_err));

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == ZERO_IDX) |-> (rd_a_data == '0));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 0, trap_enter = 0, trap_return = 0, ret_addr_lsb = 0, sel_req = 0, sel_shadow = 0;
  logic shadow_mode, switch_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .trap_enter(trap_enter), .trap_return(trap_return), .ret_addr_lsb(ret_addr_lsb),
    .sel_req(sel_req), .sel_shadow(sel_shadow),
    .shadow_mode(shadow_mode), .switch_err(switch_err));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic [63:0] d);
    wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_a(input string req, input logic [4:0] i, input logic [63:0] exp);
    rd_a_idx = i; #1;
    chk(req, rd_a_data, exp);
  endtask

  task automatic do_trap();
    trap_enter = 1; @(negedge clk); trap_enter = 0;
  endtask

  task automatic do_ret(input logic lsb);
    trap_return = 1; ret_addr_lsb = lsb; @(negedge clk); trap_return = 0; ret_addr_lsb = 0;
  endtask

  task automatic do_sel(input logic s);
    sel_req = 1; sel_shadow = s; @(negedge clk); sel_req = 0; sel_shadow = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", shadow_mode, 1);
    chk("R1 err", switch_err, 0);
    rd_a("R1 a", 5'd8, 0);
    rd_b_idx = 5'd3; #1; chk("R1 b", rd_b_data, 0);
  endtask

  task automatic t_banking();
    wr(5'd8, 64'hAAAA_0008);
    wr(5'd25, 64'hAAAA_0025);
    wr(5'd14, 64'hAAAA_0014);
    do_ret(0);
    chk("R5 ret to normal", shadow_mode, 0);
    chk("R5 no err", switch_err, 0);
    rd_a("R2 normal copy 8 empty", 5'd8, 0);
    wr(5'd8, 64'hBBBB_0008);
    wr(5'd25, 64'hBBBB_0025);
    rd_a("R2 normal 8", 5'd8, 64'hBBBB_0008);
    rd_a("R2 normal 25", 5'd25, 64'hBBBB_0025);
    do_trap();
    chk("R4 trap to fw", shadow_mode, 1);
    rd_a("R2 shadow 8", 5'd8, 64'hAAAA_0008);
    rd_a("R2 shadow 25", 5'd25, 64'hAAAA_0025);
    rd_a("R2 shadow 14", 5'd14, 64'hAAAA_0014);
  endtask

  task automatic t_unbanked();
    wr(5'd7, 64'hC7); wr(5'd15, 64'hCF); wr(5'd24, 64'hD8); wr(5'd26, 64'hDA);
    do_ret(0);
    rd_a("R3 idx7", 5'd7, 64'hC7);
    rd_a("R3 idx15", 5'd15, 64'hCF);
    rd_a("R3 idx24", 5'd24, 64'hD8);
    rd_a("R3 idx26", 5'd26, 64'hDA);
  endtask

  task automatic t_errors();
    do_ret(0);
    chk("R6 redundant ret err", switch_err, 1);
    chk("R6 mode kept", shadow_mode, 0);
    @(negedge clk);
    chk("R6 err one cycle", switch_err, 0);
    do_sel(0);
    chk("R6 redundant sel err", switch_err, 1);
    chk("R6 sel mode kept", shadow_mode, 0);
    do_sel(1);
    chk("R7 sel to fw", shadow_mode, 1);
    chk("R7 no err", switch_err, 0);
    do_trap();
    chk("R4 trap in fw no err", switch_err, 0);
    chk("R4 stays fw", shadow_mode, 1);
    do_ret(1);
    chk("R5 lsb1 keeps mode", shadow_mode, 1);
    chk("R5 lsb1 no err", switch_err, 0);
    do_sel(0);
    chk("R7 sel to normal", shadow_mode, 0);
  endtask

  task automatic t_zero();
    wr(5'd31, 64'hFFFF);
    rd_a("R8 normal r31", 5'd31, 0);
    do_trap();
    wr(5'd31, 64'hEEEE);
    rd_a("R8 fw r31", 5'd31, 0);
  endtask

  task automatic t_latency();
    rd_a_idx = 5'd20; rd_b_idx = 5'd21;
    wr_en = 1; wr_idx = 5'd20; wr_data = 64'h1234; #1;
    chk("R9 not yet visible", rd_a_data, 0);
    @(negedge clk); wr_en = 0; #1;
    chk("R9 visible next cycle", rd_a_data, 64'h1234);
    chk("R9 port b independent", rd_b_data, 0);
  endtask

  task automatic t_priority();
    trap_enter = 1; trap_return = 1; ret_addr_lsb = 0;
    @(negedge clk); trap_enter = 0; trap_return = 0;
    chk("R10 trap beats ret", shadow_mode, 1);
    chk("R10 no err", switch_err, 0);
    trap_return = 1; ret_addr_lsb = 0; sel_req = 1; sel_shadow = 1;
    @(negedge clk); trap_return = 0; sel_req = 0; sel_shadow = 0;
    chk("R10 ret beats sel", shadow_mode, 0);
    chk("R10 sel ignored no err", switch_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_banking();
    t_unbanked();
    t_errors();
    t_zero();
    t_latency();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule